// File: doc/BRIEF.md
# Hardware Breakpoint Acknowledge Sequencer

This block watches an active-low breakpoint request that arrives together with read data. It marks a fetched word with a breakpoint tag when the request is seen at a clock edge where the data is valid. The tag then travels with the word through a simple instruction pipeline model, and the block keeps a countdown of the instruction completions still to come. A tagged prefetch fires when the prefetched instruction itself completes, `PF_DEPTH` completions later. A tagged operand fetch fires when the instruction that is executing now completes. A pipeline flush throws a pending tag away without any trace.

When a tag fires, the block performs a breakpoint acknowledge bus cycle. This is a word read in CPU address space, and its address is fixed: it encodes breakpoint source 7 with the type bit set. Either a data transfer acknowledge or a bus error ends the cycle, and the block then requests breakpoint exception processing for a single cycle. If no response arrives, a watchdog ends the cycle as a bus error. When background debug is enabled, a firing tag produces a debug-entry pulse and no bus cycle is run. Only one breakpoint source exists, so there is no arbitration. The control and bus pins are plain levels and pulses, with no valid/ready handshake and no back-pressure. The bus side holds its strobes until a termination input or the watchdog ends the cycle.

Top module: `bkpt_ack_seq`

## Requirements
- R1: A tag is taken only at a rising clock edge where `rd_valid` is 1 and `bkpt_n` is 0. A low `bkpt_n` with `rd_valid` at 0 never leads to an acknowledge.
- R2: A tag on a prefetch (`fetch_is_op`=0) fires at the `PF_DEPTH`-th `insn_retire` edge after the tag (default 2). `as_o` goes high in the cycle after that edge.
- R3: A tag on an operand fetch (`fetch_is_op`=1) fires at the next `insn_retire` edge. `as_o` goes high in the cycle after that edge.
- R4: A `pipe_flush` at any edge discards the pending tag. This includes a tag sampled at that same edge. No acknowledge follows.
- R5: While `as_o` is high, the outputs hold these values:
  - `rd_o` is 1.
  - `ack_size` is 1 (word).
  - `ack_fc` is 3'b111.
  - `ack_addr` is 24'h00001E. This means bits 19:16 = 0000 (breakpoint acknowledge type), bits 4:2 = 111 (source) and bit 1 = 1 (T). All other bits are 0.
  - When no cycle is running, `ack_addr`, `ack_fc` and `ack_size` are 0.
- R6: If `term_dtack` or `term_berr` is 1 at an edge while `as_o` is high, then in the next cycle `as_o` and `rd_o` are low and `exc_req` is high for exactly one cycle.
- R7: With no termination input, `as_o` stays high for exactly `WD_LIMIT` cycles (default 16). It then drops with a one-cycle `exc_req`.
- R8: With `bdm_en` high when a tag fires, no bus cycle starts. `dbg_entry` instead goes high for exactly one cycle, in the cycle after the firing edge.
- R9: Breakpoint samples taken while an acknowledge cycle is running are ignored. No second acknowledge follows the first.
- R10: A second tag that arrives while one is pending merges into it. A single acknowledge follows, at the earlier of the two firing points.
- R11: A synchronous reset drives `as_o`, `rd_o`, `exc_req`, `dbg_entry` and the bus outputs to 0, and it clears any pending tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bkpt_n | input | 1 | Breakpoint request, active low |
| rd_valid | input | 1 | Read data valid this edge |
| fetch_is_op | input | 1 | 1 = operand fetch, 0 = instruction prefetch |
| insn_retire | input | 1 | An instruction completes execution |
| pipe_flush | input | 1 | Pipeline flush |
| bdm_en | input | 1 | Background debug enabled; replaces the bus cycle with a debug-entry pulse |
| term_dtack | input | 1 | Data transfer acknowledge termination |
| term_berr | input | 1 | Bus error termination |
| ack_addr | output | 24 | Acknowledge cycle address |
| ack_fc | output | 3 | Function code |
| ack_size | output | 1 | 1 = word transfer |
| as_o | output | 1 | Address strobe |
| rd_o | output | 1 | Read strobe |
| exc_req | output | 1 | One-cycle breakpoint exception request |
| dbg_entry | output | 1 | One-cycle debug entry pulse |

## Verification
The bench checks the two firing points against each other. A design that swaps the prefetch and operand countdowns would start the strobe one completion too early or too late. A flush that lands on the same edge as a new sample must leave nothing behind; a design that lets the sample win would run a stray acknowledge. Merged tags must produce a single acknowledge at the earlier point, so a design that keeps the later count or queues both would fire late or twice. Samples during an active cycle and a silent bus are also covered: a missing watchdog would hang with strobes held, and an off-by-one watchdog would give 15 or 17 strobe cycles.

// File: rtl/bkpt_ack_pkg.sv
package bkpt_ack_pkg;
  localparam int ADDR_W = 24;
  localparam int FC_W   = 3;
  localparam logic [FC_W-1:0] FC_CPU_SPACE  = 3'b111;
  localparam logic [3:0]      CPU_TYPE_BKPT = 4'h0;
  localparam logic [2:0]      BKPT_SOURCE   = 3'b111;
  localparam logic            BKPT_TYPE_BIT = 1'b1;

  typedef enum logic [0:0] {BUS_IDLE, BUS_ACK} bus_state_e;

  // Address of the acknowledge read, built from its fields.
  function automatic logic [ADDR_W-1:0] ack_address();
    logic [ADDR_W-1:0] a;
    a        = '0;
    a[19:16] = CPU_TYPE_BKPT;
    a[4:2]   = BKPT_SOURCE;
    a[1]     = BKPT_TYPE_BIT;
    return a;
  endfunction
endpackage

// File: rtl/bkpt_tag_track.sv
module bkpt_tag_track #(
  parameter int PF_DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bkpt_n,
  input  logic rd_valid,
  input  logic fetch_is_op,
  input  logic insn_retire,
  input  logic pipe_flush,
  input  logic busy,
  output logic fire
);
  localparam int CW = $clog2(PF_DEPTH + 1);
  localparam logic [CW-1:0] PF_CNT = CW'(PF_DEPTH);
  localparam logic [CW-1:0] OP_CNT = CW'(1);

  logic          pending;
  logic [CW-1:0] cnt;
  logic          sample;
  logic [CW-1:0] new_cnt;
  logic [CW-1:0] dec_cnt;

  always_comb begin
    sample  = rd_valid & ~bkpt_n & ~busy;
    new_cnt = fetch_is_op ? OP_CNT : PF_CNT;
    dec_cnt = (pending && insn_retire) ? cnt - OP_CNT : cnt;
    fire    = pending & insn_retire & (cnt == OP_CNT) & ~pipe_flush;
  end

  always_ff @(posedge clk) begin
    if (rst || pipe_flush || fire) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (sample) begin
      pending <= 1'b1;
      cnt     <= (pending && dec_cnt < new_cnt) ? dec_cnt : new_cnt;
    end else if (pending && insn_retire) begin
      cnt <= dec_cnt;
    end
  end

  // R4: a flush leaves nothing pending
  a_r4_flush_clears: assert property (@(posedge clk) disable iff (rst)
    pipe_flush |=> !pending);
  // R10: merged count stays inside the legal window
  a_r10_cnt_range: assert property (@(posedge clk) disable iff (rst)
    pending |-> (cnt != '0 && cnt <= PF_CNT));
  // R9: no tag gets taken while the bus cycle runs
  a_r9_busy_no_tag: assert property (@(posedge clk) disable iff (rst)
    (busy && !pending) |=> !pending);
endmodule

// File: rtl/bkpt_ack_bus.sv
module bkpt_ack_bus
  import bkpt_ack_pkg::*;
#(
  parameter int WD_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              bdm_en,
  input  logic              term_dtack,
  input  logic              term_berr,
  output logic              busy,
  output logic [ADDR_W-1:0] ack_addr,
  output logic [FC_W-1:0]   ack_fc,
  output logic              ack_size,
  output logic              as_o,
  output logic              rd_o,
  output logic              exc_req,
  output logic              dbg_entry
);
  localparam int WW = (WD_LIMIT > 1) ? $clog2(WD_LIMIT) : 1;
  localparam logic [WW-1:0] WD_LAST = WW'(WD_LIMIT - 1);

  bus_state_e    state;
  logic [WW-1:0] wd_cnt;
  logic          term;

  always_comb begin
    term     = term_dtack | term_berr;
    busy     = (state == BUS_ACK);
    as_o     = busy;
    rd_o     = busy;
    ack_addr = busy ? ack_address() : '0;
    ack_fc   = busy ? FC_CPU_SPACE : '0;
    ack_size = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= BUS_IDLE;
      wd_cnt    <= '0;
      exc_req   <= 1'b0;
      dbg_entry <= 1'b0;
    end else begin
      exc_req   <= 1'b0;
      dbg_entry <= 1'b0;
      case (state)
        BUS_IDLE: begin
          wd_cnt <= '0;
          if (fire) begin
            if (bdm_en) dbg_entry <= 1'b1;
            else        state     <= BUS_ACK;
          end
        end
        BUS_ACK: begin
          if (term || wd_cnt == WD_LAST) begin
            state   <= BUS_IDLE;
            exc_req <= 1'b1;
            wd_cnt  <= '0;
          end else begin
            wd_cnt <= wd_cnt + 1'b1;
          end
        end
        default: state <= BUS_IDLE;
      endcase
    end
  end

  a_r5_ack_encoding: assert property (@(posedge clk) disable iff (rst)
    as_o |-> (ack_addr == 24'h00001E && ack_fc == 3'b111 && ack_size && rd_o));
  a_r6_exc_single: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> !exc_req);
  a_r6_exc_after_bus: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> ($past(as_o) && !as_o));
  a_r6_strobe_hold: assert property (@(posedge clk) disable iff (rst)
    (as_o && !term && wd_cnt != WD_LAST) |=> as_o);
  a_r7_wd_bound: assert property (@(posedge clk) disable iff (rst)
    wd_cnt <= WD_LAST);
  a_r8_dbg_no_bus: assert property (@(posedge clk) disable iff (rst)
    dbg_entry |-> (!as_o && !$past(as_o)));
  a_r8_dbg_single: assert property (@(posedge clk) disable iff (rst)
    dbg_entry |=> !dbg_entry);
endmodule

// File: rtl/bkpt_ack_seq.sv
module bkpt_ack_seq
  import bkpt_ack_pkg::*;
#(
  parameter int PF_DEPTH = 2,
  parameter int WD_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bkpt_n,
  input  logic              rd_valid,
  input  logic              fetch_is_op,
  input  logic              insn_retire,
  input  logic              pipe_flush,
  input  logic              bdm_en,
  input  logic              term_dtack,
  input  logic              term_berr,
  output logic [ADDR_W-1:0] ack_addr,
  output logic [FC_W-1:0]   ack_fc,
  output logic              ack_size,
  output logic              as_o,
  output logic              rd_o,
  output logic              exc_req,
  output logic              dbg_entry
);
  logic fire;
  logic busy;

  bkpt_tag_track #(.PF_DEPTH(PF_DEPTH)) u_track (
    .clk         (clk),
    .rst         (rst),
    .bkpt_n      (bkpt_n),
    .rd_valid    (rd_valid),
    .fetch_is_op (fetch_is_op),
    .insn_retire (insn_retire),
    .pipe_flush  (pipe_flush),
    .busy        (busy),
    .fire        (fire)
  );

  bkpt_ack_bus #(.WD_LIMIT(WD_LIMIT)) u_bus (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire),
    .bdm_en     (bdm_en),
    .term_dtack (term_dtack),
    .term_berr  (term_berr),
    .busy       (busy),
    .ack_addr   (ack_addr),
    .ack_fc     (ack_fc),
    .ack_size   (ack_size),
    .as_o       (as_o),
    .rd_o       (rd_o),
    .exc_req    (exc_req),
    .dbg_entry  (dbg_entry)
  );

  // R3: no strobe without a firing tag one edge earlier
  a_r3_strobe_needs_fire: assert property (@(posedge clk) disable iff (rst)
    $rose(as_o) |-> $past(fire));
endmodule

// File: tb/bkpt_ack_seq_bench.sv
`timescale 1ns/1ps
module bkpt_ack_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bkpt_n = 1'b1, rd_valid = 1'b0, fetch_is_op = 1'b0, insn_retire = 1'b0;
  logic pipe_flush = 1'b0, bdm_en = 1'b0, term_dtack = 1'b0, term_berr = 1'b0;
  logic [23:0] ack_addr;
  logic [2:0]  ack_fc;
  logic ack_size, as_o, rd_o, exc_req, dbg_entry;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bkpt_ack_seq u_bkpt_ack_seq (
    .clk(clk), .rst(rst), .bkpt_n(bkpt_n), .rd_valid(rd_valid),
    .fetch_is_op(fetch_is_op), .insn_retire(insn_retire), .pipe_flush(pipe_flush),
    .bdm_en(bdm_en), .term_dtack(term_dtack), .term_berr(term_berr),
    .ack_addr(ack_addr), .ack_fc(ack_fc), .ack_size(ack_size), .as_o(as_o),
    .rd_o(rd_o), .exc_req(exc_req), .dbg_entry(dbg_entry));

  // Row: {bkpt_n,rd_valid,op,retire,flush,bdm,dtack,berr, exp_as,exp_exc,exp_dbg}
  localparam int NV = 26;
  localparam logic [10:0] VEC [NV] = '{
    11'b0_1_1_0_0_0_0_0_000, 11'b1_0_0_1_0_0_0_0_100, 11'b1_0_0_0_0_0_0_0_100,
    11'b1_0_0_0_0_0_1_0_010, 11'b1_0_0_0_0_0_0_0_000,
    11'b0_1_0_0_0_0_0_0_000, 11'b1_0_0_1_0_0_0_0_000, 11'b1_0_0_0_0_0_0_0_000,
    11'b1_0_0_1_0_0_0_0_100, 11'b1_0_0_0_0_0_0_1_010, 11'b1_0_0_0_0_0_0_0_000,
    11'b0_1_1_0_0_0_0_0_000, 11'b1_0_0_0_1_0_0_0_000, 11'b1_0_0_1_0_0_0_0_000,
    11'b1_0_0_1_0_0_0_0_000,
    11'b0_0_1_0_0_0_0_0_000, 11'b1_0_0_1_0_0_0_0_000,
    11'b0_1_1_0_0_1_0_0_000, 11'b1_0_0_1_0_1_0_0_001, 11'b1_0_0_0_0_1_0_0_000,
    11'b0_1_0_0_0_0_0_0_000, 11'b0_1_1_0_0_0_0_0_000, 11'b1_0_0_1_0_0_0_0_100,
    11'b1_0_0_0_0_0_1_0_010, 11'b1_0_0_1_0_0_0_0_000, 11'b1_0_0_1_0_0_0_0_000
  };

  function automatic string row_req(int i);
    if (i <= 4)  return "R3 R6";
    if (i <= 10) return "R2 R6";
    if (i <= 14) return "R4";
    if (i <= 16) return "R1";
    if (i <= 19) return "R8";
    return "R10";
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Inputs applied at a falling edge; outputs sampled at the next falling edge.
  task automatic tick(input logic [7:0] in);
    {bkpt_n, rd_valid, fetch_is_op, insn_retire, pipe_flush, bdm_en, term_dtack, term_berr} = in;
    @(posedge clk);
    @(negedge clk);
    {bkpt_n, rd_valid, fetch_is_op, insn_retire, pipe_flush, bdm_en, term_dtack, term_berr} = 8'b1000_0000;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int strobe_len;
    logic saw_exc;
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R11 reset state
    chk("R11", "as_o", as_o, 0);
    chk("R11", "exc_req", exc_req, 0);
    chk("R11", "dbg_entry", dbg_entry, 0);
    chk("R11", "ack_addr", ack_addr, 0);
    rst = 1'b0;
    tick(8'b1000_0000);
    chk("R5", "idle addr/fc/size", {ack_addr, ack_fc, ack_size}, 0);

    for (int i = 0; i < NV; i++) begin
      tick(VEC[i][10:3]);
      chk(row_req(i), $sformatf("row %0d as_o", i), as_o, VEC[i][2]);
      chk(row_req(i), $sformatf("row %0d exc_req", i), exc_req, VEC[i][1]);
      chk(row_req(i), $sformatf("row %0d dbg_entry", i), dbg_entry, VEC[i][0]);
    end

    // R4: flush on the same edge as the sample
    tick(8'b0110_1000);
    tick(8'b1001_0000);
    chk("R4", "same-edge flush as_o", as_o, 0);

    // R5 and R7: silent bus, watchdog ends the cycle
    tick(8'b0110_0000);
    tick(8'b1001_0000);
    chk("R5", "ack_addr", ack_addr, 24'h00001E);
    chk("R5", "ack_fc", ack_fc, 3'b111);
    chk("R5", "ack_size/rd_o", {ack_size, rd_o}, 2'b11);
    strobe_len = 0;
    saw_exc = 1'b0;
    while (as_o && strobe_len < 40) begin
      strobe_len++;
      tick(8'b1000_0000);
    end
    saw_exc = exc_req;
    chk("R7", "strobe length", strobe_len, 16);
    chk("R7", "exc_req at timeout", saw_exc, 1);
    tick(8'b1000_0000);
    chk("R7", "exc_req one cycle", exc_req, 0);

    // R9: samples during the acknowledge are ignored
    tick(8'b0110_0000);
    tick(8'b1001_0000);
    chk("R9", "as_o started", as_o, 1);
    tick(8'b0111_0000);
    tick(8'b0101_0000);
    tick(8'b1000_0010);
    chk("R9", "exc_req", exc_req, 1);
    tick(8'b1001_0000);
    tick(8'b1001_0000);
    chk("R9", "no second ack", as_o, 0);

    // R11: reset clears a pending tag
    tick(8'b0110_0000);
    rst = 1'b1;
    tick(8'b1000_0000);
    chk("R11", "as_o in reset", as_o, 0);
    rst = 1'b0;
    tick(8'b1001_0000);
    chk("R11", "pending cleared", as_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule